// File: doc/BRIEF.md
# Vertical sync mask and complement counter

This block cleans up a separated vertical sync pulse. It keeps a half-line counter that advances on a tick running at twice the horizontal line rate. The counter returns to zero whenever a vertical pulse is accepted. Each accepted pulse produces a one-cycle vertical detection strobe and sets a sticky interrupt flag.

After every accepted pulse, further pulses are locked out for most of the field. The lockout ends at a count that depends on the selected TV format. Once it ends it stays off until the next accepted pulse, so the following real pulse re-synchronises the counter. Noise pulses that land inside the lockout window have no effect.

When the complement enable is set and the vertical pulse goes missing, the block produces the strobe itself. It does this when the count reaches the field length for the selected format, and it then restarts the count and re-arms the lockout. With complement disabled, the counter stops at its all-ones value and waits for a real pulse. Choosing the source of the half-line tick is outside this block.

Top module: `vsync_mask_complement`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, count_o is 0, vstrobe_o is 0 and irq_flag_o is 0. The lockout starts cleared, so the first pulse after reset is accepted.
- R2: A pulse on vpulse_i that is accepted makes count_o 0 and vstrobe_o 1 on the next cycle. The strobe lasts exactly one cycle.
- R3: In a cycle with a tick, no accepted pulse and no complement reload, count_o rises by 1 on the next cycle. In a cycle with neither a tick nor a pulse, count_o holds.
- R4: In NTSC mode (fmt_pal_i = 0), pulses are ignored while the count after an accepted reset is below NTSC_MASK (446 by default). An ignored pulse changes neither count_o, vstrobe_o nor irq_flag_o.
- R5: In PAL mode (fmt_pal_i = 1), the lockout lasts while the count is below PAL_MASK (450 by default).
- R6: Once the count has reached the lockout end, the lockout stays cleared. The next pulse is accepted and restarts the count.
- R7: With comp_en_i = 1, a tick at count NTSC_FIELD-1 (524) in NTSC mode, or PAL_FIELD-1 (624) in PAL mode, gives count_o = 0, a strobe and a set flag on the next cycle. It also re-arms the lockout.
- R8: With comp_en_i = 0, no strobe appears without a pulse, and the count saturates at 2^CNT_W-1.
- R9: irq_flag_o stays 1 until irq_clr_i is asserted. When a set and a clear happen in the same cycle, the flag ends up 1.
- R10: If a pulse is accepted in the same cycle as a tick, the pulse wins and count_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vpulse_i | input | 1 | Separated vertical pulse (one per rising edge) |
| tick2h_i | input | 1 | Tick at twice the line rate |
| fmt_pal_i | input | 1 | Format select: 0 NTSC, 1 PAL |
| comp_en_i | input | 1 | Enable synthesising the strobe when the pulse is missing |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| vstrobe_o | output | 1 | One-cycle vertical detection strobe |
| irq_flag_o | output | 1 | Sticky vertical interrupt flag |
| count_o | output | CNT_W | Current half-line count |

## Verification
The bench builds the block with CNT_W = 6, NTSC_FIELD = 20, NTSC_MASK = 17, PAL_FIELD = 24 and PAL_MASK = 18. At these sizes each lockout edge, both complement reloads and counter saturation are only a few dozen ticks apart. A single run can therefore cover several full fields in each format, pulses one count before and exactly at the lockout end, and an overrun to the all-ones value with complement disabled.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

    typedef enum logic {
        FMT_NTSC = 1'b0,
        FMT_PAL  = 1'b1
    } fmt_e;

    typedef struct packed {
        logic strobe;
        logic flag;
    } evt_st_t;

endpackage

// File: rtl/vmc_limits.sv
module vmc_limits
    import vmc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int NTSC_FIELD = 525,
    parameter int PAL_FIELD  = 625,
    parameter int NTSC_MASK  = 446,
    parameter int PAL_MASK   = 450
) (
    input  logic             fmt_pal_i,
    output logic [CNT_W-1:0] field_last_o,
    output logic [CNT_W-1:0] mask_end_o
);
    localparam logic [CNT_W-1:0] NTSC_LAST = CNT_W'(NTSC_FIELD - 1);
    localparam logic [CNT_W-1:0] PAL_LAST  = CNT_W'(PAL_FIELD - 1);
    localparam logic [CNT_W-1:0] NTSC_MEND = CNT_W'(NTSC_MASK);
    localparam logic [CNT_W-1:0] PAL_MEND  = CNT_W'(PAL_MASK);

    fmt_e fmt;

    always_comb begin
        fmt = fmt_e'(fmt_pal_i);
        case (fmt)
            FMT_PAL: begin
                field_last_o = PAL_LAST;
                mask_end_o   = PAL_MEND;
            end
            default: begin
                field_last_o = NTSC_LAST;
                mask_end_o   = NTSC_MEND;
            end
        endcase
    end
endmodule

// File: rtl/vmc_counter.sv
module vmc_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vpulse_i,
    input  logic             tick_i,
    input  logic             comp_en_i,
    input  logic [CNT_W-1:0] field_last_i,
    input  logic [CNT_W-1:0] mask_end_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             masked;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    accept, reload;

    always_comb begin
        accept = vpulse_i && !st_q.masked;
        reload = !accept && tick_i && comp_en_i && (st_q.cnt == field_last_i);
        st_d   = st_q;
        fire_o = 1'b0;
        if (accept || reload) begin
            st_d.cnt    = '0;
            st_d.masked = 1'b1;
            fire_o      = 1'b1;
        end else begin
            if (tick_i && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.masked && (st_d.cnt >= mask_end_i)) begin
                st_d.masked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/vmc_event.sv
module vmc_event
    import vmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic clr_i,
    output logic strobe_o,
    output logic flag_o
);
    evt_st_t ev_d, ev_q;

    always_comb begin
        ev_d.strobe = fire_i;
        if (fire_i) begin
            ev_d.flag = 1'b1;
        end else if (clr_i) begin
            ev_d.flag = 1'b0;
        end else begin
            ev_d.flag = ev_q.flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign strobe_o = ev_q.strobe;
    assign flag_o   = ev_q.flag;
endmodule

// File: rtl/vsync_mask_complement.sv
module vsync_mask_complement #(
    parameter int CNT_W      = 10,
    parameter int NTSC_FIELD = 525,
    parameter int PAL_FIELD  = 625,
    parameter int NTSC_MASK  = 446,
    parameter int PAL_MASK   = 450
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vpulse_i,
    input  logic             tick2h_i,
    input  logic             fmt_pal_i,
    input  logic             comp_en_i,
    input  logic             irq_clr_i,
    output logic             vstrobe_o,
    output logic             irq_flag_o,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] field_last;
    logic [CNT_W-1:0] mask_end;
    logic             fire;

    vmc_limits #(
        .CNT_W      (CNT_W),
        .NTSC_FIELD (NTSC_FIELD),
        .PAL_FIELD  (PAL_FIELD),
        .NTSC_MASK  (NTSC_MASK),
        .PAL_MASK   (PAL_MASK)
    ) u_limits (
        .fmt_pal_i    (fmt_pal_i),
        .field_last_o (field_last),
        .mask_end_o   (mask_end)
    );

    vmc_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .vpulse_i     (vpulse_i),
        .tick_i       (tick2h_i),
        .comp_en_i    (comp_en_i),
        .field_last_i (field_last),
        .mask_end_i   (mask_end),
        .fire_o       (fire),
        .count_o      (count_o)
    );

    vmc_event u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .clr_i    (irq_clr_i),
        .strobe_o (vstrobe_o),
        .flag_o   (irq_flag_o)
    );
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vpulse_i,
    input logic             tick2h_i,
    input logic             comp_en_i,
    input logic             irq_clr_i,
    input logic             vstrobe_o,
    input logic             irq_flag_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    assert_strobe_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vstrobe_o |-> (count_o == '0));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vstrobe_o |=> !vstrobe_o);

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick2h_i && !vpulse_i) |=> $stable(count_o));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick2h_i && !vpulse_i && !comp_en_i && (count_o != ALL_ONES))
        |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpulse_i && !comp_en_i && (count_o == ALL_ONES)) |=> (count_o == ALL_ONES));

    assert_no_synth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpulse_i && !comp_en_i) |=> !vstrobe_o);

    assert_flag_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vstrobe_o |-> irq_flag_o);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_i |=> (irq_flag_o == vstrobe_o));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !irq_clr_i) |=> irq_flag_o);
endmodule

bind vsync_mask_complement vmc_checker #(.CNT_W(CNT_W)) u_vmc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .vpulse_i   (vpulse_i),
    .tick2h_i   (tick2h_i),
    .comp_en_i  (comp_en_i),
    .irq_clr_i  (irq_clr_i),
    .vstrobe_o  (vstrobe_o),
    .irq_flag_o (irq_flag_o),
    .count_o    (count_o)
);

// File: tb/tb_vsync_mask_complement.sv
module tb_vsync_mask_complement;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int NF         = 20;
    localparam int PF         = 24;
    localparam int NM         = 17;
    localparam int PM         = 18;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0;
    logic vpulse = 0, tick = 0, pal = 0, comp = 0, clr = 0;
    logic vstrobe, irq;
    logic [CNT_W-1:0] count;

    int n_chk = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_mask = 0, m_irq = 0, m_strobe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsync_mask_complement #(
        .CNT_W(CNT_W), .NTSC_FIELD(NF), .PAL_FIELD(PF), .NTSC_MASK(NM), .PAL_MASK(PM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .vpulse_i(vpulse), .tick2h_i(tick), .fmt_pal_i(pal),
        .comp_en_i(comp), .irq_clr_i(clr), .vstrobe_o(vstrobe), .irq_flag_o(irq),
        .count_o(count)
    );

    typedef struct packed {
        logic       p, t, c, f, e;
        logic [7:0] reps;
        logic [3:0] req;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  4'd2},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd10, 4'd3},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  4'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7,  4'd3},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  4'd6},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd25, 4'd7},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  4'd9},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1,  4'd5},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd30, 4'd7},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  4'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, advanced once per clock edge from the requirements
    task automatic model_edge();
        int last, mend;
        bit acc, fire;
        last = pal ? PF - 1 : NF - 1;
        mend = pal ? PM : NM;
        acc  = vpulse && !m_mask;
        fire = acc || (tick && comp && (m_cnt == last));
        if (fire) begin
            m_cnt = 0;
            m_mask = 1;
        end else begin
            if (tick && m_cnt != MAXV) m_cnt++;
            if (m_mask && m_cnt >= mend) m_mask = 0;
        end
        m_strobe = fire;
        if (fire) m_irq = 1;
        else if (clr) m_irq = 0;
    endtask

    task automatic step(input bit p, input bit t, input bit c, input string req);
        vpulse = p; tick = t; clr = c;
        @(posedge clk);
        model_edge();
        #(CLK_PERIOD/4);
        chk(int'(count) == m_cnt, {req, " count"}, int'(count), m_cnt);
        chk(vstrobe == m_strobe, {req, " strobe"}, int'(vstrobe), int'(m_strobe));
        chk(irq == m_irq, {req, " flag"}, int'(irq), int'(m_irq));
        @(negedge clk);
        vpulse = 0; tick = 0; clr = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk(count == 0 && vstrobe == 0 && irq == 0, "R1 in reset", int'(count), 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(count == 0 && vstrobe == 0 && irq == 0, "R1 after reset", int'(count), 0);
        @(negedge clk);

        for (int r = 0; r < NROWS; r++) begin
            pal = TBL[r].f;
            comp = TBL[r].e;
            for (int k = 0; k < int'(TBL[r].reps); k++)
                step(TBL[r].p, TBL[r].t, TBL[r].c, $sformatf("R%0d row%0d", TBL[r].req, r));
        end

        // R8: complement off, counter stops at all ones, no strobe
        comp = 0; pal = 0;
        for (int k = 0; k < 70; k++) step(0, 1, 0, "R8 run");
        chk(int'(count) == MAXV, "R8 saturate", int'(count), MAXV);
        chk(vstrobe == 0, "R8 no strobe", int'(vstrobe), 0);

        // R10: pulse and tick together
        comp = 1;
        step(1, 1, 0, "R10");
        chk(count == 0 && vstrobe == 1, "R10 pulse wins", int'(count), 0);

        // R4 / R6 NTSC lockout edge
        for (int k = 0; k < NM - 1; k++) step(0, 1, 0, "R4 run");
        step(1, 0, 0, "R4");
        chk(int'(count) == NM - 1 && vstrobe == 0, "R4 ignored", int'(count), NM - 1);
        step(0, 1, 0, "R6 run");
        step(1, 0, 0, "R6");
        chk(count == 0 && vstrobe == 1, "R6 accepted", int'(count), 0);

        // R5 / R6 PAL lockout edge
        pal = 1;
        for (int k = 0; k < PM - 1; k++) step(0, 1, 0, "R5 run");
        step(1, 0, 0, "R5");
        chk(int'(count) == PM - 1 && vstrobe == 0, "R5 ignored", int'(count), PM - 1);
        step(0, 1, 0, "R6 run");
        step(1, 0, 0, "R6");
        chk(count == 0 && vstrobe == 1, "R6 accepted pal", int'(count), 0);

        // R9 clear, then set-wins at the R7 reload
        step(0, 0, 1, "R9");
        chk(irq == 0, "R9 cleared", int'(irq), 0);
        for (int k = 0; k < PF - 1; k++) step(0, 1, 0, "R7 run");
        step(0, 1, 1, "R9");
        chk(irq == 1, "R9 set wins", int'(irq), 1);
        chk(count == 0 && vstrobe == 1, "R7 reload", int'(count), 0);
        step(1, 0, 0, "R7");
        chk(vstrobe == 0 && count == 0, "R7 lockout rearmed", int'(vstrobe), 0);
        step(0, 0, 0, "R9");
        chk(irq == 1, "R9 sticky", int'(irq), 1);

        finish_run();
    end
endmodule